// File: doc/BRIEF.md
# Memory-Mapped Configuration Address Translator

This block sits behind a 4 MiB region of the CPU address map on a host bridge. It turns each CPU load or store in that region into one configuration-space transaction. The upper address bits carry a one-hot device-select field. The block scans that field from its lowest bit upward, and the position of the first set bit becomes a binary device number. The low eleven address bits pass through unchanged as the function and register part of the configuration address. Any access that falls outside the region is accepted and dropped.

Reads and writes of 1, 2 or 4 bytes are supported, with little-endian lane ordering. The block derives byte enables from the access size and the two low address bits. It moves write bytes onto their lanes, and it moves read bytes back down to the low end of the response. The block holds one request at a time. It lowers its ready signal from the moment it accepts an access until the configuration port answers. When the configuration port reports that no device responded, a read returns all ones.

Top module: `cfg_window_xlate`

## Requirements
- R1: An accepted access whose address bits [31:22] equal 0x202 (CPU range 0x8080_0000 to 0x80BF_FFFF) produces exactly one configuration request with the same read/write direction. An accepted access outside that range produces no configuration request and no response, and ready stays high.
- R2: Configuration address bits [10:0] equal CPU address bits [10:0].
- R3: When any of CPU address bits 11..21 is set, configuration address bits [14:11] hold the index i (0..10) of the lowest set bit, where bit 11+i is that bit.
- R4: When none of CPU address bits 11..21 is set, configuration address bits [14:11] hold 11.
- R5: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. The byte enables are the low n bits set, shifted left by address bits [1:0]. Lanes beyond lane 3 are dropped.
- R6: On a write, byte k of the CPU write data (byte 0 = bits [7:0]) appears on configuration lane addr[1:0]+k for every enabled lane.
- R7: On a read, configuration lane addr[1:0]+k is returned in byte k of the response. Bytes at or above the access size, and bytes with no source lane, read as zero.
- R8: A read whose configuration response flags no device returns all ones in the bytes of the access size and zero above.
- R9: The configuration request valid is a one-cycle pulse in the cycle after acceptance. Ready is low from that cycle until the cycle after the configuration response.
- R10: The CPU response valid pulses for one cycle, in the cycle after the configuration response valid is sampled. A write response carries zero data.
- R11: During and straight after reset, ready is high and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access present |
| cpu_req_ready | output | 1 | Block idle and able to accept |
| cpu_req_addr | input | 32 | CPU byte address |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| cpu_req_wdata | input | 32 | Write data, right-aligned |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_rdata | output | 32 | Read data, right-aligned |
| cfg_req_valid | output | 1 | Configuration request pulse |
| cfg_req_addr | output | 15 | Device number [14:11], function/register [10:0] |
| cfg_req_write | output | 1 | Configuration write |
| cfg_req_be | output | 4 | Byte-lane enables |
| cfg_req_wdata | output | 32 | Lane-placed write data |
| cfg_rsp_valid | input | 1 | Configuration response |
| cfg_rsp_rdata | input | 32 | Configuration read data on lanes |
| cfg_rsp_nodev | input | 1 | No device answered |

## Verification
The configuration request, with its address, enables and lanes, is due in the cycle after the accepting edge. The CPU response is due in the cycle after the edge that samples the configuration response. Ready must be low between these two points. The monitor samples two nanoseconds after each rising edge, and it records the configuration response level at the edge itself. The stand-in responder adds zero to five cycles of latency, so the response and ready timing is checked for both immediate and delayed answers. For accesses outside the window, the bench waits several cycles and confirms that no request or response counter moved.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } cfgx_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cfgx_state_e;

    // Unshifted lane mask for an access size (up to eight lanes).
    function automatic logic [7:0] size_lanes(input cfgx_size_e s);
        case (s)
            SZ_BYTE: size_lanes = 8'h01;
            SZ_HALF: size_lanes = 8'h03;
            default: size_lanes = 8'h0F;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_dev_scan.sv
module cfgx_dev_scan #(
    parameter int SEL_COUNT = 11,
    parameter int DEV_W     = 4
) (
    input  logic [SEL_COUNT-1:0] sel,
    output logic [DEV_W-1:0]     dev_num
);

    logic [SEL_COUNT:0]   seen;
    logic [SEL_COUNT-1:0] first;

    assign seen[0] = 1'b0;

    // Ripple chain: first[g] marks the lowest set select line.
    for (genvar g = 0; g < SEL_COUNT; g++) begin : g_chain
        assign first[g]  = sel[g] & ~seen[g];
        assign seen[g+1] = seen[g] | sel[g];
    end

    always_comb begin
        dev_num = seen[SEL_COUNT] ? '0 : DEV_W'(SEL_COUNT);
        for (int i = 0; i < SEL_COUNT; i++) begin
            if (first[i]) begin
                dev_num = dev_num | DEV_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfgx_lane_pack.sv
module cfgx_lane_pack
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  cfgx_size_e        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_wdata
);

    logic [7:0]       lanes_all;
    logic [LANES-1:0] base_mask;

    assign lanes_all  = size_lanes(size);
    assign base_mask  = lanes_all[LANES-1:0];
    assign be         = base_mask << off;
    assign lane_wdata = wdata << {off, 3'b000};

endmodule

// File: rtl/cfgx_lane_unpack.sv
module cfgx_lane_unpack
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  cfgx_size_e        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_write,
    input  logic              nodev,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic [DATA_W-1:0] rdata
);

    logic [7:0]        lanes_all;
    logic [LANES-1:0]  keep;
    logic [DATA_W-1:0] byte_mask;
    logic [DATA_W-1:0] aligned;

    assign lanes_all = size_lanes(size);
    assign keep      = lanes_all[LANES-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign byte_mask[8*g +: 8] = {8{keep[g]}};
    end

    assign aligned = lane_rdata >> {off, 3'b000};

    always_comb begin
        if (is_write) begin
            rdata = '0;
        end else if (nodev) begin
            rdata = byte_mask;
        end else begin
            rdata = aligned & byte_mask;
        end
    end

endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
    import cfgx_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8080_0000,
    parameter int                WIN_AW    = 22,
    parameter int                SEL_LO    = 11,
    parameter int                SEL_COUNT = 11,
    parameter int                DATA_W    = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cpu_req_valid,
    output logic                                      cpu_req_ready,
    input  logic [ADDR_W-1:0]                         cpu_req_addr,
    input  logic                                      cpu_req_write,
    input  logic [1:0]                                cpu_req_size,
    input  logic [DATA_W-1:0]                         cpu_req_wdata,
    output logic                                      cpu_rsp_valid,
    output logic [DATA_W-1:0]                         cpu_rsp_rdata,
    output logic                                      cfg_req_valid,
    output logic [SEL_LO+$clog2(SEL_COUNT+1)-1:0]     cfg_req_addr,
    output logic                                      cfg_req_write,
    output logic [DATA_W/8-1:0]                       cfg_req_be,
    output logic [DATA_W-1:0]                         cfg_req_wdata,
    input  logic                                      cfg_rsp_valid,
    input  logic [DATA_W-1:0]                         cfg_rsp_rdata,
    input  logic                                      cfg_rsp_nodev
);

    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int DEV_W  = $clog2(SEL_COUNT + 1);
    localparam int CFG_AW = SEL_LO + DEV_W;

    typedef struct packed {
        cfgx_state_e        state;
        logic               req_v;
        logic [CFG_AW-1:0]  addr;
        logic               we;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic [OFF_W-1:0]   off;
        cfgx_size_e         size;
        logic               rsp_v;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t r_q, r_d;

    // Request-side decode
    logic                 in_win;
    logic [DEV_W-1:0]     dev_num;
    logic [LANES-1:0]     be_new;
    logic [DATA_W-1:0]    wdata_new;
    logic [DATA_W-1:0]    rd_val;
    cfgx_size_e           size_in;
    logic [OFF_W-1:0]     off_in;

    assign in_win  = (cpu_req_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
    assign size_in = cfgx_size_e'(cpu_req_size);
    assign off_in  = cpu_req_addr[OFF_W-1:0];

    cfgx_dev_scan #(
        .SEL_COUNT (SEL_COUNT),
        .DEV_W     (DEV_W)
    ) scan_i (
        .sel     (cpu_req_addr[SEL_LO +: SEL_COUNT]),
        .dev_num (dev_num)
    );

    cfgx_lane_pack #(
        .DATA_W (DATA_W)
    ) pack_i (
        .size       (size_in),
        .off        (off_in),
        .wdata      (cpu_req_wdata),
        .be         (be_new),
        .lane_wdata (wdata_new)
    );

    // Response-side alignment uses the held request attributes
    cfgx_lane_unpack #(
        .DATA_W (DATA_W)
    ) unpack_i (
        .size       (r_q.size),
        .off        (r_q.off),
        .is_write   (r_q.we),
        .nodev      (cfg_rsp_nodev),
        .lane_rdata (cfg_rsp_rdata),
        .rdata      (rd_val)
    );

    always_comb begin
        r_d       = r_q;
        r_d.req_v = 1'b0;
        r_d.rsp_v = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (cpu_req_valid && in_win) begin
                    r_d.state = ST_WAIT;
                    r_d.req_v = 1'b1;
                    r_d.addr  = {dev_num, cpu_req_addr[SEL_LO-1:0]};
                    r_d.we    = cpu_req_write;
                    r_d.be    = be_new;
                    r_d.wdata = wdata_new;
                    r_d.off   = off_in;
                    r_d.size  = size_in;
                end
            end
            ST_WAIT: begin
                if (cfg_rsp_valid) begin
                    r_d.state = ST_IDLE;
                    r_d.rsp_v = 1'b1;
                    r_d.rdata = rd_val;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_req_ready = (r_q.state == ST_IDLE);
    assign cpu_rsp_valid = r_q.rsp_v;
    assign cpu_rsp_rdata = r_q.rdata;
    assign cfg_req_valid = r_q.req_v;
    assign cfg_req_addr  = r_q.addr;
    assign cfg_req_write = r_q.we;
    assign cfg_req_be    = r_q.be;
    assign cfg_req_wdata = r_q.wdata;

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8080_0000,
    parameter int                WIN_AW    = 22,
    parameter int                SEL_LO    = 11,
    parameter int                SEL_COUNT = 11,
    parameter int                DATA_W    = 32
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  cpu_req_valid,
    input logic                                  cpu_req_ready,
    input logic [ADDR_W-1:0]                     cpu_req_addr,
    input logic                                  cpu_rsp_valid,
    input logic                                  cfg_req_valid,
    input logic [SEL_LO+$clog2(SEL_COUNT+1)-1:0] cfg_req_addr,
    input logic [DATA_W/8-1:0]                   cfg_req_be,
    input logic                                  cfg_rsp_valid
);

    localparam int CFG_AW = SEL_LO + $clog2(SEL_COUNT + 1);

    logic in_win;
    assign in_win = (cpu_req_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);

    a_r1_inside_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && in_win) |=> cfg_req_valid);

    a_r1_outside_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && !in_win) |=> (!cfg_req_valid && cpu_req_ready));

    a_r3_dev_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_addr[CFG_AW-1:SEL_LO] <= ($clog2(SEL_COUNT + 1))'(SEL_COUNT)));

    a_r5_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_be != '0));

    a_r9_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |=> !cfg_req_valid);

    a_r9_busy_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> !cpu_req_ready);

    a_r10_rsp_follows_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> $past(cfg_rsp_valid));

    a_r10_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

endmodule

bind cfg_window_xlate cfgx_checker #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_AW    (WIN_AW),
    .SEL_LO    (SEL_LO),
    .SEL_COUNT (SEL_COUNT),
    .DATA_W    (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_addr  (cfg_req_addr),
    .cfg_req_be    (cfg_req_be),
    .cfg_rsp_valid (cfg_rsp_valid)
);

// File: tb/cfg_window_xlate_tb_top.sv
`timescale 1ns/1ps
module cfg_window_xlate_tb_top;

    logic        clk;
    logic        rst_n;
    logic        cpu_req_valid;
    logic        cpu_req_ready;
    logic [31:0] cpu_req_addr;
    logic        cpu_req_write;
    logic [1:0]  cpu_req_size;
    logic [31:0] cpu_req_wdata;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        cfg_req_valid;
    logic [14:0] cfg_req_addr;
    logic        cfg_req_write;
    logic [3:0]  cfg_req_be;
    logic [31:0] cfg_req_wdata;
    logic        cfg_rsp_valid;
    logic [31:0] cfg_rsp_rdata;
    logic        cfg_rsp_nodev;

    typedef struct packed {
        logic [14:0] addr;
        logic        we;
        logic [3:0]  be;
        logic [31:0] wdata;
    } cfg_item_t;

    cfg_item_t   exp_cfg_q[$];
    logic [31:0] exp_rsp_q[$];
    string       exp_tag_q[$];

    int tests = 0;
    int fails = 0;
    int cfg_seen = 0;
    int rsp_seen = 0;

    logic [31:0] rsp_data_v = '0;
    logic        rsp_nodev_v = 1'b0;
    int          rsp_lat_v = 0;
    logic        rsp_at_edge;

    cfg_window_xlate dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_ready (cpu_req_ready),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_write (cpu_req_write),
        .cpu_req_size  (cpu_req_size),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .cfg_req_valid (cfg_req_valid),
        .cfg_req_addr  (cfg_req_addr),
        .cfg_req_write (cfg_req_write),
        .cfg_req_be    (cfg_req_be),
        .cfg_req_wdata (cfg_req_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_rdata (cfg_rsp_rdata),
        .cfg_rsp_nodev (cfg_rsp_nodev)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stand-in configuration responder
    initial begin
        cfg_rsp_valid = 1'b0;
        cfg_rsp_rdata = '0;
        cfg_rsp_nodev = 1'b0;
        forever begin
            @(posedge clk);
            #3;
            if (rst_n && cfg_req_valid) begin
                repeat (rsp_lat_v) @(posedge clk);
                @(negedge clk);
                cfg_rsp_valid = 1'b1;
                cfg_rsp_rdata = rsp_data_v;
                cfg_rsp_nodev = rsp_nodev_v;
                @(negedge clk);
                cfg_rsp_valid = 1'b0;
                cfg_rsp_nodev = 1'b0;
            end
        end
    end

    // Monitor / scoreboard
    always @(posedge clk) begin
        cfg_item_t   it;
        logic [31:0] lm;
        logic [31:0] er;
        string       tg;
        rsp_at_edge = cfg_rsp_valid;
        #2;
        if (rst_n) begin
            if (cfg_req_valid) begin
                cfg_seen++;
                if (exp_cfg_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected configuration request", {17'b0, cfg_req_addr}, 32'h0);
                end else begin
                    it = exp_cfg_q.pop_front();
                    chk(cfg_req_write == it.we, "R1 direction", {31'b0, cfg_req_write}, {31'b0, it.we});
                    chk(cfg_req_addr[10:0] == it.addr[10:0], "R2 low address passthrough",
                        {21'b0, cfg_req_addr[10:0]}, {21'b0, it.addr[10:0]});
                    chk(cfg_req_addr[14:11] == it.addr[14:11],
                        (it.addr[14:11] == 4'd11) ? "R4 device number with no select" : "R3 device number",
                        {28'b0, cfg_req_addr[14:11]}, {28'b0, it.addr[14:11]});
                    chk(cfg_req_be == it.be, "R5 byte enables", {28'b0, cfg_req_be}, {28'b0, it.be});
                    if (it.we) begin
                        for (int k = 0; k < 4; k++) lm[8*k +: 8] = {8{it.be[k]}};
                        chk((cfg_req_wdata & lm) == (it.wdata & lm), "R6 write lanes",
                            cfg_req_wdata & lm, it.wdata & lm);
                    end
                end
            end
            if (cpu_rsp_valid || rsp_at_edge) begin
                chk(cpu_rsp_valid && rsp_at_edge, "R10 response one cycle after configuration response",
                    {31'b0, cpu_rsp_valid}, {31'b0, rsp_at_edge});
            end
            if (cpu_rsp_valid) begin
                rsp_seen++;
                if (exp_rsp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected response", cpu_rsp_rdata, 32'h0);
                end else begin
                    er = exp_rsp_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    chk(cpu_rsp_rdata == er, tg, cpu_rsp_rdata, er);
                end
            end
        end
    end

    // Driver: computes expectations from the requirements and issues one access
    task automatic access(input logic [31:0] a, input bit w, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] rd, input bit nd, input int lat);
        bit          fwd;
        int          nb;
        int          off;
        logic [3:0]  dev;
        logic [7:0]  be8;
        logic [63:0] wl;
        logic [31:0] bm;
        logic [31:0] rexp;
        cfg_item_t   it;
        int          rb;
        int          cb;
        fwd = (a[31:22] == 10'h202);
        nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        off = int'(a[1:0]);
        dev = 4'd11;
        for (int i = 10; i >= 0; i--) if (a[11+i]) dev = 4'(i);
        be8 = 8'(((1 << nb) - 1) << off);
        wl  = {32'b0, wd} << (off * 8);
        bm  = (nb == 4) ? 32'hFFFF_FFFF : 32'((64'd1 << (8 * nb)) - 64'd1);
        rexp = w ? 32'h0 : (nd ? bm : ((rd >> (off * 8)) & bm));
        if (fwd) begin
            it.addr  = {dev, a[10:0]};
            it.we    = w;
            it.be    = be8[3:0];
            it.wdata = wl[31:0];
            exp_cfg_q.push_back(it);
            exp_rsp_q.push_back(rexp);
            exp_tag_q.push_back(w ? "R10 write response data zero" :
                                (nd ? "R8 no-device read" : "R7 read lane alignment"));
        end
        rsp_data_v  = rd;
        rsp_nodev_v = nd;
        rsp_lat_v   = lat;
        rb = rsp_seen;
        cb = cfg_seen;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        cpu_req_write = w;
        cpu_req_size  = sz;
        cpu_req_wdata = wd;
        @(posedge clk);
        #1;
        cpu_req_valid = 1'b0;
        #2;
        if (fwd) begin
            chk(!cpu_req_ready, "R9 ready low after acceptance", {31'b0, cpu_req_ready}, 32'h0);
            if (lat >= 2) begin
                repeat (2) @(posedge clk);
                #3;
                chk(!cpu_req_ready, "R9 ready held low while waiting", {31'b0, cpu_req_ready}, 32'h0);
            end
            wait (rsp_seen == rb + 1);
            chk(cpu_req_ready, "R9 ready back after response", {31'b0, cpu_req_ready}, 32'h1);
        end else begin
            chk(cpu_req_ready, "R1 ready stays high outside window", {31'b0, cpu_req_ready}, 32'h1);
            repeat (4) @(posedge clk);
            #3;
            chk(cfg_seen == cb, "R1 no request outside window", 32'(cfg_seen), 32'(cb));
            chk(rsp_seen == rb, "R1 no response outside window", 32'(rsp_seen), 32'(rb));
        end
    endtask

    initial begin
        rst_n         = 1'b0;
        cpu_req_valid = 1'b0;
        cpu_req_addr  = '0;
        cpu_req_write = 1'b0;
        cpu_req_size  = '0;
        cpu_req_wdata = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(cpu_req_ready, "R11 ready high in reset", {31'b0, cpu_req_ready}, 32'h1);
        chk(!cpu_rsp_valid, "R11 no response in reset", {31'b0, cpu_rsp_valid}, 32'h0);
        chk(!cfg_req_valid, "R11 no request in reset", {31'b0, cfg_req_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(cpu_req_ready && !cpu_rsp_valid && !cfg_req_valid, "R11 idle after reset",
            {29'b0, cpu_req_ready, cpu_rsp_valid, cfg_req_valid}, 32'h4);

        access(32'h8080_0800, 1'b0, 2'd2, 32'h0, 32'h1122_3344, 1'b0, 0); // R3 dev 0
        access(32'h80A0_0004, 1'b0, 2'd2, 32'h0, 32'hCAFE_F00D, 1'b0, 1); // R3 dev 10
        access(32'h8080_5006, 1'b0, 2'd0, 32'h0, 32'hAABB_CCDD, 1'b0, 0); // R3 lowest wins, R7
        access(32'h8080_07FF, 1'b0, 2'd0, 32'h0, 32'hAABB_CCDD, 1'b0, 2); // R4 dev 11
        access(32'h8081_0082, 1'b1, 2'd1, 32'h0000_BEEF, 32'h0, 1'b0, 0); // R6 half write
        access(32'h8080_1003, 1'b1, 2'd2, 32'h1234_5678, 32'h0, 1'b0, 3); // R5 truncated lanes
        access(32'h8082_0012, 1'b0, 2'd1, 32'h0, 32'h0, 1'b1, 0);         // R8 half
        access(32'h8080_0400, 1'b0, 2'd2, 32'h0, 32'h0, 1'b1, 5);         // R8 word, R9 long wait
        access(32'h807F_FFFC, 1'b0, 2'd2, 32'h0, 32'h0, 1'b0, 0);         // R1 below window
        access(32'h80C0_0000, 1'b1, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b0, 0); // R1 above window
        access(32'h80BF_E1E5, 1'b0, 2'd3, 32'h0, 32'h0102_0304, 1'b0, 1); // R5 size code 3
        access(32'h8088_0003, 1'b0, 2'd1, 32'h0, 32'h5566_7788, 1'b0, 0); // R7 missing lane
        access(32'h8080_0000, 1'b1, 2'd0, 32'h0000_00A5, 32'h0, 1'b0, 0); // R4 byte write

        repeat (3) @(posedge clk);
        #3;
        chk(exp_cfg_q.size() == 0, "R1 all expected requests seen", 32'(exp_cfg_q.size()), 32'h0);
        chk(exp_rsp_q.size() == 0, "R10 all expected responses seen", 32'(exp_rsp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule